// File: doc/BRIEF.md
# Front-Panel Indicator Blink Controller

This block lights three status lamps on a front panel: a trigger lamp, an error lamp and a pending-entry lamp. A slow tick, derived from the display's timing, advances an 8-bit prescaler. The top three bits of that prescaler are the blink phase. They are decoded into a blink waveform that is high for five of every eight phases. A 4-bit control word chooses what each lamp shows. The trigger lamp can be off, steady or blinking. The other two lamps can only be off or blinking.

A level input marks a system-wide logic reset. While it is high, every lamp is dark, but the prescaler keeps counting. A separate synchronous reset clears the prescaler and the lamps. Every lamp output comes from a register, so a control change appears at the next clock edge and has no combinational glitches.

Top module: `blink_panel`

## Requirements
- R1: The 8-bit prescaler advances by one, wrapping from 255 to 0, on each clock edge where `tick_en` is high. It holds its value when `tick_en` is low.
- R2: The blink phase is prescaler bits 7:5. The blink waveform is high for phases 0 to 4 and low for phases 5 to 7, so it is high for 160 of every 256 counts.
- R3: The trigger lamp (`lamp_trig`) works as follows. When `ctrl[3]` is 0 the lamp is off. When `ctrl[3]` is 1 and `ctrl[2]` is 0 the lamp is lit steadily. When both bits are 1 the lamp follows the blink waveform.
- R4: The error lamp (`lamp_err`) follows the blink waveform when `ctrl[1]` is 1 and is off when `ctrl[1]` is 0. It has no steady mode.
- R5: The pending-entry lamp (`lamp_pend`) follows the blink waveform when `ctrl[0]` is 1 and is off when `ctrl[0]` is 0.
- R6: While `logic_rst` is high, all three lamps are low one edge later, including the steady trigger lamp. `logic_rst` has no effect on the prescaler.
- R7: When `rst` is high at a clock edge, the prescaler is cleared to 0 and all lamps are driven low.
- R8: Each lamp is registered. Its value after an edge is computed from the prescaler value and the `ctrl` and `logic_rst` values that were present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | One-cycle tick that advances the prescaler |
| logic_rst | input | 1 | Logic-reset level; blanks all lamps while high |
| ctrl | input | 4 | Lamp control: [3] trigger on, [2] trigger blink, [1] error, [0] pending |
| lamp_trig | output | 1 | Trigger lamp drive, active high |
| lamp_err | output | 1 | Error lamp drive, active high |
| lamp_pend | output | 1 | Pending-entry lamp drive, active high |

## Verification
A directed sweep uses one tick per cycle with all control bits set, across more than a full 256-count period. This exposes the exact phase edges at count 160 and at the wrap, which separates a 5/8 decode from a half-duty decode or a shifted one. Runs with `tick_en` held low show that the lamps freeze, which separates a ticked prescaler from a free-running one. A `logic_rst` pulse with the trigger lamp in steady mode checks that the blanking also covers the steady path. It then shows that counting continued during the pulse. Random control words, ticks and logic-reset pulses mix all lamp modes at every phase.

// File: rtl/blink_panel.sv
module blink_panel #(
  parameter int CNT_W     = 8,
  parameter int PHASE_W   = 3,
  parameter int ON_PHASES = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       logic_rst,
  input  logic [3:0] ctrl,
  output logic       lamp_trig,
  output logic       lamp_err,
  output logic       lamp_pend
);

  localparam int PH_LO = CNT_W - PHASE_W;

  logic [CNT_W-1:0]   cnt;
  logic [PHASE_W-1:0] phase;
  logic               blink;
  logic               trig_d;

  assign phase  = cnt[CNT_W-1:PH_LO];
  assign blink  = (int'(phase) < ON_PHASES) && !logic_rst;
  assign trig_d = ctrl[3] && !logic_rst && (ctrl[2] ? blink : 1'b1);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (tick_en) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lamp_trig <= 1'b0;
      lamp_err  <= 1'b0;
      lamp_pend <= 1'b0;
    end else begin
      lamp_trig <= trig_d;
      lamp_err  <= ctrl[1] && blink;
      lamp_pend <= ctrl[0] && blink;
    end
  end

  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt));

  p_err_pend_agree_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl[1] && ctrl[0]) |=> (lamp_err == lamp_pend));

  p_trig_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl[3] && !ctrl[2] && !logic_rst) |=> lamp_trig);

  p_err_dark_r4: assert property (@(posedge clk) disable iff (rst)
    !ctrl[1] |=> !lamp_err);

  p_pend_dark_r5: assert property (@(posedge clk) disable iff (rst)
    !ctrl[0] |=> !lamp_pend);

  p_blank_r6: assert property (@(posedge clk) disable iff (rst)
    logic_rst |=> !(lamp_trig || lamp_err || lamp_pend));

  p_reset_dark_r7: assert property (@(posedge clk)
    rst |=> (!lamp_trig && !lamp_err && !lamp_pend && cnt == '0));

endmodule

// File: tb/test_blink_panel.sv
module test_blink_panel;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, tick_en, logic_rst;
  logic [3:0] ctrl;
  logic lamp_trig, lamp_err, lamp_pend;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mcnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blink_panel i_blink_panel (
    .clk(clk), .rst(rst), .tick_en(tick_en), .logic_rst(logic_rst),
    .ctrl(ctrl), .lamp_trig(lamp_trig), .lamp_err(lamp_err), .lamp_pend(lamp_pend)
  );

  function automatic logic exp_blink(input logic [7:0] c, input logic lr);
    return (c[7:5] <= 3'd4) && !lr;
  endfunction

  function automatic logic exp_trig(input logic [7:0] c, input logic lr, input logic [3:0] k);
    if (lr || !k[3]) return 1'b0;
    return k[2] ? exp_blink(c, lr) : 1'b1;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (model count %0d)", tag, act, exp, mcnt);
    end
  endtask

  task automatic step(input logic tk, input logic lr, input logic [3:0] k, input string tag);
    logic et, ee, ep;
    @(negedge clk);
    tick_en = tk; logic_rst = lr; ctrl = k;
    @(posedge clk);
    et = exp_trig(mcnt, lr, k);
    ee = k[1] && exp_blink(mcnt, lr);
    ep = k[0] && exp_blink(mcnt, lr);
    if (tk) mcnt = mcnt + 8'd1;
    #1;
    check({tag, "/R3 trig"}, lamp_trig, et);
    check({tag, "/R4 err"},  lamp_err,  ee);
    check({tag, "/R5 pend"}, lamp_pend, ep);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; tick_en = 1'b0; logic_rst = 1'b0; ctrl = 4'hF;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset trig", lamp_trig, 1'b0);
    check("R7 reset err",  lamp_err,  1'b0);
    check("R7 reset pend", lamp_pend, 1'b0);
    @(negedge clk); rst = 1'b0; mcnt = '0;

    // R2 full sweep: phase edges at 160 and wrap
    for (int i = 0; i < 300; i++) step(1'b1, 1'b0, 4'hF, "R2 sweep");
    // R1 hold with no tick: lamps must freeze
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 4'hF, "R1 hold");
    // R3 steady mode
    for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 4'b1000, "R3 steady");
    // R6 blanking, counter keeps running
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 4'hF, "R6 blank");
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 4'b1011, "R6 after");
    // R8 control change visible after one edge
    step(1'b0, 1'b0, 4'b1000, "R8 on");
    step(1'b0, 1'b0, 4'b0000, "R8 off");
    // R7 mid-run reset clears counter
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R7 midrun trig", lamp_trig, 1'b0);
    @(negedge clk); rst = 1'b0; mcnt = '0;
    for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 4'b0011, "R7 restart");

    // random mix
    for (int i = 0; i < 4000; i++)
      step(1'($urandom % 3 != 0), 1'($urandom % 16 == 0), 4'($urandom), "rand");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule